// File: doc/BRIEF.md
# Dual-Mode Pulse and Oscillator Timer

This block is a clocked multivibrator. With both run enables inactive it acts as a one-shot. An edge on either trigger input makes the true output high for exactly N clocks, where N is taken from the count input. A combined edge on the positive trigger and the retrigger input restarts that N-clock window. With either run enable active it becomes a free-running square-wave source. The true output toggles every N clocks, and a secondary oscillator output runs at twice that rate.

The count input takes the place of an external resistor and capacitor. It is sampled at the start of each pulse and of each oscillation period, so software or a neighbouring block can change it at any time without corrupting the interval in progress. All inputs are assumed to be synchronous to `clk` already. Edges are found by comparing each input with its value on the previous clock.

Top module: `pulse_osc_timer`

## Requirements
- R1: While `rst` is high, at every clock `q` becomes 0, `q_n` becomes 1 and `osc` becomes 0, and any pulse or oscillation in progress is abandoned.
- R2: `q_n` is at all times the bitwise inverse of `q`.
- R3: In one-shot mode, a 0-to-1 change on `trig_rise` seen at a clock edge makes `q` high from that edge for exactly N clocks.
- R4: In one-shot mode, a 1-to-0 change on `trig_fall` starts the same N-clock pulse as R3.
- R5: The pulse width does not depend on how long a trigger is held. A trigger level held steady, including one held through reset, starts no pulse.
- R6: A trigger edge that arrives during a pulse, without the retrigger condition, leaves the pulse end unchanged.
- R7: A 0-to-1 change on `trig_rise` and `retrig` at the same clock during a pulse keeps `q` high for N clocks counted from that clock. A `retrig` edge on its own has no effect.
- R8: A trigger edge seen on the first clock at which `q` is already low starts a new pulse.
- R9: While `run_en` is 1 or `run_en_n` is 0, `q` goes high on the next clock and then toggles every N clocks, giving a 50% duty cycle.
- R10: In free-running mode, `osc` has period N clocks. It is high for floor(N/2) clocks starting on each `q` toggle and low for the rest of the period. Outside free-running mode, `osc` is 0.
- R11: When both run enables become inactive, `q` and `osc` are 0 from the next clock.
- R12: N is captured from `period` at the start of every pulse, retrigger and oscillation period. A value below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Free-running enable, active high |
| run_en_n | input | 1 | Free-running enable, active low |
| trig_rise | input | 1 | One-shot trigger on a rising edge |
| trig_fall | input | 1 | One-shot trigger on a falling edge |
| retrig | input | 1 | Retrigger qualifier, used together with a rising edge on trig_rise |
| period | input | CNT_W | Timing count N |
| q | output | 1 | True main output |
| q_n | output | 1 | Complement main output |
| osc | output | 1 | Double-rate oscillator output |

## Verification
The bench holds `trig_rise` high through the release of reset and for many clocks after a pulse. A design that triggers on level, or that loses its previous-value registers at reset, would fire a spurious pulse. It retriggers three clocks into a pulse and also pulses `retrig` alone. A design that mixes up the combined condition would either cut the pulse short at its first end point or stretch it when it should not. The count input is changed in the middle of a pulse and in the middle of an oscillation period, and a zero count is applied. A design that reads the count live instead of capturing it would end the interval early or stall on a zero count. Pulses are placed back to back to catch a lost recovery clock, and odd counts are used to check that `osc` falls at floor(N/2) rather than at a rounded-up point.

// File: rtl/pulse_osc_timer.sv
module pulse_osc_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             run_en_n,
  input  logic             trig_rise,
  input  logic             trig_fall,
  input  logic             retrig,
  input  logic [CNT_W-1:0] period,
  output logic             q,
  output logic             q_n,
  output logic             osc
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] MIN_N = CNT_W'(2);

  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_RUN} state_t;

  state_t st;
  logic [CNT_W-1:0] ph, nlat;
  logic rise_d, fall_d, retrig_d;

  wire free_run   = run_en | ~run_en_n;
  wire rise_evt   = trig_rise & ~rise_d;
  wire fall_evt   = ~trig_fall & fall_d;
  wire fire       = rise_evt | fall_evt;
  wire retrig_evt = rise_evt & retrig & ~retrig_d;
  wire [CNT_W-1:0] n_eff = (period < MIN_N) ? MIN_N : period;
  wire [CNT_W-1:0] half  = nlat >> 1;
  wire last = (ph == nlat - ONE);

  assign q_n = ~q;

  always_ff @(posedge clk) begin
    rise_d   <= trig_rise;
    fall_d   <= trig_fall;
    retrig_d <= retrig;
    if (rst) begin
      st   <= ST_IDLE;
      q    <= 1'b0;
      osc  <= 1'b0;
      ph   <= '0;
      nlat <= MIN_N;
    end else if (free_run && st != ST_RUN) begin
      st   <= ST_RUN;
      q    <= 1'b1;
      osc  <= 1'b1;
      ph   <= '0;
      nlat <= n_eff;
    end else if (!free_run && st == ST_RUN) begin
      st  <= ST_IDLE;
      q   <= 1'b0;
      osc <= 1'b0;
      ph  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (fire) begin
            st   <= ST_PULSE;
            q    <= 1'b1;
            ph   <= '0;
            nlat <= n_eff;
          end
        end
        ST_PULSE: begin
          if (retrig_evt) begin
            ph   <= '0;
            nlat <= n_eff;
          end else if (last) begin
            st <= ST_IDLE;
            q  <= 1'b0;
            ph <= '0;
          end else begin
            ph <= ph + ONE;
          end
        end
        ST_RUN: begin
          if (last) begin
            ph   <= '0;
            q    <= ~q;
            osc  <= 1'b1;
            nlat <= n_eff;
          end else begin
            ph <= ph + ONE;
            if (ph + ONE == half) osc <= 1'b0;
          end
        end
        default: begin
          st <= ST_IDLE;
          q  <= 1'b0;
        end
      endcase
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!q && !osc));

  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !free_run && fire) |=> q);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PULSE && !free_run && !retrig_evt && !last) |=> q);

  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PULSE && !free_run && retrig_evt) |=> (q && ph == '0));

  a_r10_osc_rise: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && free_run && last) |=> (osc && q != $past(q)));

  a_r11_stop: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !free_run) |=> (!q && !osc));

  a_r12_min_count: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> (nlat >= MIN_N));

endmodule

// File: tb/pulse_osc_timer_tb_top.sv
module pulse_osc_timer_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic run_en_n = 1'b1;
  logic trig_rise = 1'b1;
  logic trig_fall = 1'b1;
  logic retrig = 1'b0;
  logic [W-1:0] period = W'(4);
  logic q, q_n, osc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct { bit q; bit osc; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  pulse_osc_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .run_en_n(run_en_n),
    .trig_rise(trig_rise), .trig_fall(trig_fall), .retrig(retrig),
    .period(period), .q(q), .q_n(q_n), .osc(osc)
  );

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (q !== e.q || osc !== e.osc) begin
        errors++;
        $display("FAIL %s: q=%b osc=%b expected q=%b osc=%b at %0t", e.tag, q, osc, e.q, e.osc, $time);
      end
      checks++;
      if (q_n !== ~q) begin
        errors++;
        $display("FAIL R2: q_n=%b expected %b at %0t", q_n, ~q, $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected <= 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input bit eq, input bit eo, input string tag);
    exp_t e;
    @(posedge clk);
    e.q = eq; e.osc = eo; e.tag = tag;
    sb.push_back(e);
    #1;
  endtask

  task automatic ticks(input int n, input bit eq, input bit eo, input string tag);
    for (int i = 0; i < n; i++) tick(eq, eo, tag);
  endtask

  task automatic run_pattern(input int n, input int count, input string tag);
    for (int i = 0; i < count; i++)
      tick(((i / n) % 2) == 0, (i % n) < (n / 2), tag);
  endtask

  initial begin
    // R1 reset state, triggers held high through reset
    ticks(3, 0, 0, "R1");
    rst = 1'b0;
    // R5 level held across reset release starts nothing
    ticks(3, 0, 0, "R5");

    // R3 rising trigger, N=5, trigger held high the whole time (R5)
    trig_rise = 1'b0; period = W'(5);
    tick(0, 0, "R3");
    trig_rise = 1'b1;
    ticks(5, 1, 0, "R3");
    tick(0, 0, "R3");
    ticks(3, 0, 0, "R5");

    // R4 falling trigger, N=3
    period = W'(3); trig_fall = 1'b0;
    ticks(3, 1, 0, "R4");
    ticks(2, 0, 0, "R4");

    // R6 edges during a pulse are ignored
    period = W'(6); trig_rise = 1'b0; trig_fall = 1'b1;
    tick(0, 0, "R6");
    trig_rise = 1'b1; tick(1, 0, "R6");
    trig_rise = 1'b0; tick(1, 0, "R6");
    trig_fall = 1'b1; tick(1, 0, "R6");
    trig_fall = 1'b0; tick(1, 0, "R6");
    trig_rise = 1'b1; tick(1, 0, "R6");
    tick(1, 0, "R6");
    tick(0, 0, "R6");
    trig_rise = 1'b0; trig_fall = 1'b1;
    tick(0, 0, "R6");

    // R7 retrigger three clocks in, N=6
    trig_rise = 1'b1; tick(1, 0, "R7");
    trig_rise = 1'b0; ticks(2, 1, 0, "R7");
    trig_rise = 1'b1; retrig = 1'b1; tick(1, 0, "R7");
    ticks(5, 1, 0, "R7");
    tick(0, 0, "R7");
    trig_rise = 1'b0; retrig = 1'b0; tick(0, 0, "R7");
    // R7 retrig alone does not extend, N=3
    period = W'(3);
    trig_rise = 1'b1; tick(1, 0, "R7");
    trig_rise = 1'b0; tick(1, 0, "R7");
    retrig = 1'b1; tick(1, 0, "R7");
    tick(0, 0, "R7");
    retrig = 1'b0;

    // R8 back-to-back pulses, N=2
    period = W'(2);
    trig_rise = 1'b1; tick(1, 0, "R8");
    trig_rise = 1'b0; tick(1, 0, "R8");
    tick(0, 0, "R8");
    trig_rise = 1'b1; tick(1, 0, "R8");
    trig_rise = 1'b0; tick(1, 0, "R8");
    tick(0, 0, "R8");

    // R12 zero count acts as 2; mid-pulse change has no effect
    period = W'(0);
    trig_rise = 1'b1; tick(1, 0, "R12");
    trig_rise = 1'b0; tick(1, 0, "R12");
    tick(0, 0, "R12");
    period = W'(4);
    trig_rise = 1'b1; tick(1, 0, "R12");
    trig_rise = 1'b0; period = W'(1);
    ticks(3, 1, 0, "R12");
    tick(0, 0, "R12");

    // R9/R10 free-running via run_en, N=4
    period = W'(4); run_en = 1'b1;
    run_pattern(4, 12, "R10");
    // R11 disable
    run_en = 1'b0;
    ticks(2, 0, 0, "R11");

    // R9/R10 free-running via run_en_n, odd N=5
    period = W'(5); run_en_n = 1'b0;
    run_pattern(5, 15, "R9");
    run_en_n = 1'b1;
    ticks(2, 0, 0, "R11");

    // R12 period change mid-oscillation: 4 then 6
    period = W'(4); run_en = 1'b1;
    tick(1, 1, "R12"); tick(1, 1, "R12");
    period = W'(6);
    tick(1, 0, "R12"); tick(1, 0, "R12");
    for (int i = 4; i < 10; i++) tick(0, i <= 6, "R12");
    tick(1, 1, "R12");
    run_en = 1'b0;
    tick(0, 0, "R11");

    // R1 reset aborts a pulse
    period = W'(8);
    trig_rise = 1'b1; tick(1, 0, "R1");
    trig_rise = 1'b0; tick(1, 0, "R1");
    rst = 1'b1; tick(0, 0, "R1");
    rst = 1'b0; ticks(3, 0, 0, "R1");
    // R1 reset aborts oscillation
    run_en = 1'b1; period = W'(4);
    ticks(2, 1, 1, "R9");
    rst = 1'b1; run_en = 1'b0; tick(0, 0, "R1");
    rst = 1'b0; ticks(2, 0, 0, "R1");

    @(negedge clk); #1;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule